// File: doc/BRIEF.md
# Shared-Prescaler Input Debounce Filter

This block cleans up to 32 input pins before they reach edge and level detection for interrupts. Every pin passes through a two-stage synchroniser. A pin whose filter is switched on then changes its output only after its input has held one value across two consecutive samples of a slow sampling tick. All pins share one tick, made by a single 24-bit prescaler that divides the block clock by a programmable value. So a pulse shorter than one tick period can never reach the interrupt logic.

A pin is filtered only when its bit in the filter-enable mask is set and its interrupt is enabled. In every other case the output is the synchronised input. Software sets the mask and the divisor with two word writes on a simple write port. Writing the divisor restarts the shared count, so the sampling phase after a write is known. After reset the filter state is loaded from the synchronised inputs. Because of this, no edge appears when filtering is already on at reset.

Top module: `dbf_debounce_top`

## Requirements
- R1: A write with `cfg_addr` = 0x40 loads the filter-enable mask from `cfg_wdata` (bit i controls pin i). A write with `cfg_addr` = 0x44 loads the divisor from `cfg_wdata[23:0]`, and bits 31:24 are ignored. Writes to any other address change nothing.
- R2: The prescaler counts from 0 to divisor−1 and raises the tick for one cycle at divisor−1. A divisor of 0 or 1 gives a tick on every cycle.
- R3: A divisor write restarts the count at 0 on the write edge E, so the first ticks are consumed on edges E+divisor and E+2·divisor.
- R4: A filtered pin's output changes only on a tick edge, and only when the synchronised input equals the sample taken at the previous tick. A pulse shorter than one tick period is rejected.
- R5: When a pin's mask bit or `irq_en` bit is 0, `pin_out` is the input delayed by the two synchroniser stages, with no filtering.
- R6: With a divisor of 0 or 1, a filtered pin's output follows an input change four clock edges later.
- R7: For SYNC_STAGES+1 cycles after reset release, the filter state is loaded from the synchronised inputs. A pin that is filtered from reset therefore shows its input level without waiting for ticks. The reset mask is all ones and the reset divisor is 16.
- R8: Writing 0 to the mask turns off filtering on every pin.
- R9: The mask acts per pin: a filtered pin rejects a short pulse while an unfiltered neighbour passes the same pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the prescaler source |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Write strobe for the configuration registers |
| cfg_addr | input | 8 | Word address of the write |
| cfg_wdata | input | 32 | Write data |
| irq_en | input | 32 | Per-pin interrupt enable from the detection logic |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Filtered or synchronised pin levels to the interrupt logic |

## Verification
The two functions that can meet in one cycle are a divisor write, which restarts the count, and a running count that is about to tick. Either of them can also land while a filtered pin is mid-transition. The bench provokes this by writing a new divisor while the old divisor of 8 is running at an arbitrary phase, and by changing the pin in the very next cycle. It then judges the result by the exact edge on which the output moves. That edge is E+20 for a divisor of 10, and only a count that truly restarted on the write edge lands there. Short pulses are judged cycle by cycle: over the whole window, the output must never move.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
  localparam int CFG_ADDR_W = 8;
  localparam int CFG_DATA_W = 32;
  localparam int DIV_W      = 24;
  localparam logic [CFG_ADDR_W-1:0] ADDR_MASK = 8'h40;
  localparam logic [CFG_ADDR_W-1:0] ADDR_DIV  = 8'h44;
endpackage

// File: rtl/dbf_rst_sync.sv
module dbf_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= 2'b00;
    else          chain_q <= {chain_q[0], 1'b1};
  end

  assign rst_n_o = chain_q[1];
endmodule

// File: rtl/dbf_prescaler.sv
module dbf_prescaler #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = (div_i <= W'(1)) || (cnt_q == div_i - W'(1));
    if (restart_i || tick_o) cnt_d = '0;
    else                     cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_i > W'(1)) |-> (cnt_q < div_i));

  // R3
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt_q == '0));
endmodule

// File: rtl/dbf_pin_filter.sv
module dbf_pin_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic prime_i,
  input  logic tick_i,
  input  logic use_i,
  output logic out_o
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic sync_val;
  logic smp_q, smp_d;
  logic stb_q, stb_d;

  assign sync_val = sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pin_i};
    smp_d  = smp_q;
    stb_d  = stb_q;
    if (prime_i || !use_i) begin
      smp_d = sync_val;
      stb_d = sync_val;
    end else if (tick_i) begin
      smp_d = sync_val;
      if (sync_val == smp_q) stb_d = sync_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      smp_q  <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      sync_q <= sync_d;
      smp_q  <= smp_d;
      stb_q  <= stb_d;
    end
  end

  assign out_o = use_i ? stb_q : sync_val;

  // R4
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && use_i && !prime_i) |=> $stable(stb_q));

  // R4
  agree_before_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && use_i && !prime_i && (sync_val != smp_q)) |=> $stable(stb_q));
endmodule

// File: rtl/dbf_debounce_top.sv
module dbf_debounce_top
  import dbf_pkg::*;
#(
  parameter int                N_PINS      = 32,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DIV_W-1:0]  RST_DIV     = 24'd16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [CFG_ADDR_W-1:0] cfg_addr,
  input  logic [CFG_DATA_W-1:0] cfg_wdata,
  input  logic [N_PINS-1:0]     irq_en,
  input  logic [N_PINS-1:0]     pin_in,
  output logic [N_PINS-1:0]     pin_out
);
  localparam int PRIME_CYC = SYNC_STAGES + 1;
  localparam int PRIME_W   = $clog2(PRIME_CYC + 1);

  logic               rst_int_n;
  logic [N_PINS-1:0]  mask_q, mask_d;
  logic [DIV_W-1:0]   div_q, div_d;
  logic               mask_wr, div_wr;
  logic [PRIME_W-1:0] prime_q, prime_d;
  logic               priming;
  logic               tick;
  logic [N_PINS-1:0]  pin_use;

  dbf_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_int_n)
  );

  always_comb begin
    mask_wr = cfg_we && (cfg_addr == ADDR_MASK);
    div_wr  = cfg_we && (cfg_addr == ADDR_DIV);
    mask_d  = mask_wr ? cfg_wdata[N_PINS-1:0] : mask_q;
    div_d   = div_wr  ? cfg_wdata[DIV_W-1:0]  : div_q;
    priming = (prime_q != PRIME_W'(PRIME_CYC));
    prime_d = priming ? prime_q + PRIME_W'(1) : prime_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mask_q  <= '1;
      div_q   <= RST_DIV;
      prime_q <= '0;
    end else begin
      mask_q  <= mask_d;
      div_q   <= div_d;
      prime_q <= prime_d;
    end
  end

  dbf_prescaler #(.W(DIV_W)) u_prescaler (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .restart_i (div_wr),
    .div_i     (div_q),
    .tick_o    (tick)
  );

  assign pin_use = mask_q & irq_en;

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    dbf_pin_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filter (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .pin_i   (pin_in[i]),
      .prime_i (priming),
      .tick_i  (tick),
      .use_i   (pin_use[i]),
      .out_o   (pin_out[i])
    );
  end

  // R7
  prime_ends_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !priming |=> !priming);

  // R1
  div_load_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !div_wr |=> $stable(div_q));
endmodule

// File: tb/dbf_debounce_top_tb_top.sv
module dbf_debounce_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] irq_en;
  logic [31:0] pin_in;
  logic [31:0] pin_out;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  dbf_debounce_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .irq_en    (irq_en),
    .pin_in    (pin_in),
    .pin_out   (pin_out)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Returns on the negedge after the write edge E.
  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step(1);
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
  endtask

  task automatic t_reset_prime;
    pin_in = 32'hA5A5_0F0F;
    irq_en = '1;
    rst_n  = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(8);
    chk("R7 primed output after reset", pin_out, 32'hA5A5_0F0F);
  endtask

  task automatic t_passthrough;
    cfg_write(8'h40, 32'h0);
    step(2);
    pin_in = 32'h1234_5678;
    step(1);
    chk("R5 passthrough one edge", pin_out, 32'hA5A5_0F0F);
    step(1);
    chk("R5 passthrough two edges", pin_out, 32'h1234_5678);
  endtask

  task automatic t_irq_gate;
    cfg_write(8'h44, 32'd100);
    cfg_write(8'h40, 32'hFFFF_FFFF);
    irq_en = '0;
    step(3);
    pin_in = 32'h0000_FFFF;
    step(2);
    chk("R5 irq_en low bypasses filter", pin_out, 32'h0000_FFFF);
    irq_en = '1;
  endtask

  task automatic t_fast_div(input logic [31:0] dv, input logic [31:0] pat);
    logic [31:0] old;
    cfg_write(8'h44, dv);
    step(10);
    old = pin_out;
    pin_in = pat;
    step(3);
    chk("R6 fast divisor holds at edge 3", pin_out, old);
    step(1);
    chk("R2 fast divisor updates at edge 4", pin_out, pat);
  endtask

  task automatic t_glitch_reject;
    logic [31:0] base;
    int bad;
    cfg_write(8'h44, 32'd8);
    step(30);
    base = pin_in;
    chk("R4 settled before pulse", pin_out, base);
    bad = 0;
    pin_in = ~base;
    for (int k = 0; k < 3; k++) begin
      step(1);
      if (pin_out !== base) bad++;
    end
    pin_in = base;
    for (int k = 0; k < 40; k++) begin
      step(1);
      if (pin_out !== base) bad++;
    end
    chk("R4 short pulse rejected (bad cycles)", bad, 0);
    pin_in = 32'hF0F0_3C3C;
    step(40);
    chk("R4 held change accepted", pin_out, 32'hF0F0_3C3C);
  endtask

  task automatic t_restart;
    cfg_write(8'h44, 32'h0100_000A);
    pin_in = 32'h0F0F_00FF;
    step(19);
    chk("R3 no update before edge E+20", pin_out, 32'hF0F0_3C3C);
    step(1);
    chk("R3 R1 update on edge E+20 (upper bits ignored)", pin_out, 32'h0F0F_00FF);
  endtask

  task automatic t_per_pin;
    cfg_write(8'h44, 32'd8);
    cfg_write(8'h40, 32'h0000_0001);
    step(30);
    pin_in = 32'h0;
    step(30);
    pin_in = 32'h3;
    step(2);
    chk("R9 filtered bit0 rejects, bit1 passes", pin_out & 32'h3, 32'h2);
    pin_in = 32'h0;
    step(30);
  endtask

  task automatic t_mask_zero;
    cfg_write(8'h40, 32'h0);
    step(3);
    pin_in = 32'hFFFF_FFFF;
    step(2);
    chk("R8 zero mask passes pulse on all pins", pin_out, 32'hFFFF_FFFF);
    pin_in = 32'h0;
    step(5);
  endtask

  task automatic t_bad_addr;
    cfg_write(8'h48, 32'hFFFF_FFFF);
    step(3);
    pin_in = 32'h8000_0001;
    step(2);
    chk("R1 write to other address ignored", pin_out, 32'h8000_0001);
  endtask

  initial begin
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    t_reset_prime();
    t_passthrough();
    t_irq_gate();
    cfg_write(8'h40, 32'hFFFF_FFFF);
    t_fast_div(32'd0, 32'h5555_AAAA);
    t_fast_div(32'd1, 32'hAAAA_5555);
    t_glitch_reject();
    t_restart();
    t_per_pin();
    t_mask_zero();
    t_bad_addr();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule